// File: doc/BRIEF.md
# DDR Region Security Access Filter

This block is a memory firewall placed in front of a DRAM port. Software programs up to eight address windows on a 1 MB grain. Each window has an inclusive start and end megabyte index and a secure-enable bit. A control word also carries two more settings. The first makes all memory outside the enabled windows secure. The second is a master bypass that opens the whole memory.

Each access request carries an address and a non-secure attribute. One clock later the block answers allow or deny. A non-secure request is refused when it lands in an enabled window, or when it lands outside every enabled window while outside memory is marked secure. A refusal raises a sticky violation flag and records the first offending address. Software clears the flag through a status register.

Configuration uses a 32-bit write port with a write mask. The upper half of the write word selects which of the lower 16 bits take effect. This lets software change one enable bit without disturbing the others.

Top module: `ddr_guard`

## Requirements
- R1: After reset, all window indices read 0, the control word (register 16) reads 0x0200 (bypass set, no windows enabled, outside memory open), and the violation flag is 0.
- R2: A write to registers 0 to 16 updates data bit i (i in 0..15) only where write bit 16+i is 1; the other stored bits keep their value.
- R3: Registers 0 to 7 hold the start index and registers 8 to 15 hold the end index of windows 0 to 7. Each index is 12 bits wide. Data bits 15:12 of a write are dropped. Reads return the index zero-extended, and bits 31:16 of every read are 0.
- R4: Window n matches a request when start <= addr[31:20] <= end, with both ends inclusive. A window whose start is greater than its end matches nothing.
- R5: A request with non-secure attribute 1 whose address matches a window whose enable bit is set (control bit n for window n) is denied, unless bypass is set.
- R6: When control bit 8 is 1, a non-secure request that matches no enabled window is denied, unless bypass is set.
- R7: When control bit 9 (bypass) is 1, every request is allowed.
- R8: A request with non-secure attribute 0 is always allowed.
- R9: rspValid and rspAllow appear exactly one clock after the request is sampled. rspValid is 1 only in cycles that follow a request.
- R10: A denial sets violFlag in the same cycle that its response appears. violAddr takes the request address only when the flag was clear before, and it holds while the flag stays set.
- R11: Register 17 reads the flag in bit 0. Writing register 17 with data bit 0 = 1 clears the flag, and no write mask is needed. If a denial arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register index for read and write |
| regWdata | input | 32 | Write word: mask in 31:16, data in 15:0 |
| regRdata | output | 32 | Read data for regAddr, combinational |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 32 | Access byte address |
| reqNs | input | 1 | 1 = non-secure access |
| rspValid | output | 1 | Decision valid, one cycle after the request |
| rspAllow | output | 1 | 1 = access allowed |
| violFlag | output | 1 | Sticky violation flag |
| violAddr | output | 32 | Address of the first denied access |

## Verification
The assertions assume that rstN is low for at least one clock edge before any request. They also assume that the register and request inputs change only away from the rising edge, so each request and each write is seen in exactly one sampled cycle. The bench drives every input on the falling edge and holds it for one full cycle. This keeps all stimulus within those assumptions. Random register writes and accesses are packed into the lowest sixteen megabyte indices. This keeps window hits, edge hits and empty windows frequent.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;
  localparam int NUM_WIN     = 8;
  localparam int ADDR_W      = 32;
  localparam int GRAN_SHIFT  = 20;
  localparam int IDX_W       = ADDR_W - GRAN_SHIFT;
  localparam int HALF_W      = 16;
  localparam int CFG_REG     = 2 * NUM_WIN;
  localparam int STAT_REG    = CFG_REG + 1;
  localparam int RADDR_W     = $clog2(STAT_REG + 1);
  localparam int BIT_OUTSIDE = NUM_WIN;
  localparam int BIT_BYPASS  = NUM_WIN + 1;
  localparam logic [HALF_W-1:0] CFG_RESET = HALF_W'(1) << BIT_BYPASS;

  typedef struct packed {
    logic [2*NUM_WIN-1:0] winWr;
    logic                 cfgWr;
    logic                 clrViol;
    logic [HALF_W-1:0]    mask;
    logic [HALF_W-1:0]    data;
  } cfgStrobe_t;
endpackage

// File: rtl/ddr_guard_regctl.sv
module ddr_guard_regctl
  import ddr_guard_pkg::*;
(
  input  logic                regWe,
  input  logic [RADDR_W-1:0]  regAddr,
  input  logic [2*HALF_W-1:0] regWdata,
  output cfgStrobe_t          strobe
);
  always_comb begin
    strobe       = '0;
    strobe.mask  = regWdata[2*HALF_W-1:HALF_W];
    strobe.data  = regWdata[HALF_W-1:0];
    if (regWe) begin
      for (int i = 0; i < 2 * NUM_WIN; i++)
        strobe.winWr[i] = (regAddr == RADDR_W'(i));
      strobe.cfgWr   = (regAddr == RADDR_W'(CFG_REG));
      strobe.clrViol = (regAddr == RADDR_W'(STAT_REG)) && regWdata[0];
    end
  end
endmodule

// File: rtl/ddr_guard_dp.sv
module ddr_guard_dp
  import ddr_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [RADDR_W-1:0]  regAddr,
  output logic [2*HALF_W-1:0] regRdata,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqNs,
  output logic                rspValid,
  output logic                rspAllow,
  output logic                violFlag,
  output logic [ADDR_W-1:0]   violAddr
);
  logic [NUM_WIN-1:0][IDX_W-1:0] winLo, winHi;
  logic [HALF_W-1:0]             cfgReg;
  logic [NUM_WIN-1:0]            hitVec;
  logic [IDX_W-1:0]              reqIdx;
  logic                          deny;

  wire [IDX_W-1:0] idxMask = strobe.mask[IDX_W-1:0];
  wire [IDX_W-1:0] idxData = strobe.data[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winLo  <= '0;
      winHi  <= '0;
      cfgReg <= CFG_RESET;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (strobe.winWr[w])
          winLo[w] <= (winLo[w] & ~idxMask) | (idxData & idxMask);
        if (strobe.winWr[w+NUM_WIN])
          winHi[w] <= (winHi[w] & ~idxMask) | (idxData & idxMask);
      end
      if (strobe.cfgWr)
        cfgReg <= (cfgReg & ~strobe.mask) | (strobe.data & strobe.mask);
    end
  end

  assign reqIdx = reqAddr[ADDR_W-1:GRAN_SHIFT];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    assign hitVec[w] = cfgReg[w] && (reqIdx >= winLo[w]) && (reqIdx <= winHi[w]);
  end

  assign deny = reqValid && reqNs && !cfgReg[BIT_BYPASS] &&
                ((|hitVec) || cfgReg[BIT_OUTSIDE]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b1;
      violFlag <= 1'b0;
      violAddr <= '0;
    end else begin
      rspValid <= reqValid;
      rspAllow <= !deny;
      if (deny) begin
        violFlag <= 1'b1;
        if (!violFlag) violAddr <= reqAddr;
      end else if (strobe.clrViol) begin
        violFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr < RADDR_W'(NUM_WIN))
      regRdata[IDX_W-1:0] = winLo[regAddr[$clog2(NUM_WIN)-1:0]];
    else if (regAddr < RADDR_W'(CFG_REG))
      regRdata[IDX_W-1:0] = winHi[regAddr[$clog2(NUM_WIN)-1:0]];
    else if (regAddr == RADDR_W'(CFG_REG))
      regRdata[HALF_W-1:0] = cfgReg;
    else if (regAddr == RADDR_W'(STAT_REG))
      regRdata[0] = violFlag;
  end
endmodule

// File: rtl/ddr_guard.sv
module ddr_guard
  import ddr_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [RADDR_W-1:0]  regAddr,
  input  logic [2*HALF_W-1:0] regWdata,
  output logic [2*HALF_W-1:0] regRdata,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqNs,
  output logic                rspValid,
  output logic                rspAllow,
  output logic                violFlag,
  output logic [ADDR_W-1:0]   violAddr
);
  cfgStrobe_t strobe;

  ddr_guard_regctl u_ctl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe)
  );

  ddr_guard_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .regRdata (regRdata),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqNs    (reqNs),
    .rspValid (rspValid),
    .rspAllow (rspAllow),
    .violFlag (violFlag),
    .violAddr (violAddr)
  );
endmodule

// File: rtl/ddr_guard_chk.sv
module ddr_guard_chk
  import ddr_guard_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [RADDR_W-1:0]  regAddr,
  input logic [2*HALF_W-1:0] regWdata,
  input logic                reqValid,
  input logic                reqNs,
  input logic                rspValid,
  input logic                rspAllow,
  input logic                violFlag,
  input logic [ADDR_W-1:0]   violAddr
);
  wire clrReq = regWe && (regAddr == RADDR_W'(STAT_REG)) && regWdata[0];

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R8
  secure_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqNs) |=> rspAllow);
  // R10
  deny_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAllow) |-> violFlag);
  // R10
  addr_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    violFlag |=> $stable(violAddr));
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violFlag && !clrReq) |=> violFlag);
endmodule

bind ddr_guard ddr_guard_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .reqValid (reqValid),
  .reqNs    (reqNs),
  .rspValid (rspValid),
  .rspAllow (rspAllow),
  .violFlag (violFlag),
  .violAddr (violAddr)
);

// File: tb/sim_ddr_guard.sv
`timescale 1ns/1ps
module sim_ddr_guard;
  logic        clk = 0;
  logic        rstN = 0;
  logic        regWe = 0;
  logic [4:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic        reqValid = 0;
  logic [31:0] reqAddr = 0;
  logic        reqNs = 0;
  logic        rspValid, rspAllow, violFlag;
  logic [31:0] violAddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddr_guard u0 (.*);

  // behavioural reference model
  logic [11:0] mLo [8];
  logic [11:0] mHi [8];
  logic [15:0] mCfg;
  bit          mFlag, mValid, mAllow;
  logic [31:0] mAddr;

  function automatic logic [15:0] wmask(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] modelRead(int a);
    if (a < 8)        return {20'd0, mLo[a]};
    else if (a < 16)  return {20'd0, mHi[a-8]};
    else if (a == 16) return {16'd0, mCfg};
    else if (a == 17) return {31'd0, mFlag};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mLo[i]) begin mLo[i] = 0; mHi[i] = 0; end
      mCfg = 16'h0200; mFlag = 0; mAddr = 0; mValid = 0; mAllow = 1;
    end else begin
      bit inWin, den;
      int idx;
      idx = int'(reqAddr >> 20);
      inWin = 0;
      for (int i = 0; i < 8; i++)
        if (mCfg[i] && idx >= int'(mLo[i]) && idx <= int'(mHi[i])) inWin = 1;
      den = reqValid && reqNs && !mCfg[9] && (inWin || mCfg[8]);
      mValid = reqValid;
      mAllow = !den;
      if (den) begin
        if (!mFlag) mAddr = reqAddr;
        mFlag = 1;
      end else if (regWe && regAddr == 17 && regWdata[0]) mFlag = 0;
      if (regWe) begin
        if (regAddr < 8) mLo[regAddr] = 12'(wmask({4'd0, mLo[regAddr]}, regWdata));
        else if (regAddr < 16) mHi[regAddr-8] = 12'(wmask({4'd0, mHi[regAddr-8]}, regWdata));
        else if (regAddr == 16) mCfg = wmask(mCfg, regWdata);
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(rspValid == mValid, "R9 rspValid", 32'(rspValid), 32'(mValid));
      if (mValid) chk(rspAllow == mAllow, "R5 rspAllow", 32'(rspAllow), 32'(mAllow));
      chk(violFlag == mFlag, "R10 violFlag", 32'(violFlag), 32'(mFlag));
      chk(violAddr == mAddr, "R10 violAddr", violAddr, mAddr);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = 5'(a); regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rdChk(int a, logic [31:0] exp, string tag);
    regAddr = 5'(a); #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic acc(logic [31:0] a, bit ns);
    @(negedge clk); reqValid = 1; reqAddr = a; reqNs = ns;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic accChk(logic [31:0] a, bit ns, bit expAllow, string tag);
    acc(a, ns);
    chk(rspAllow == expAllow, tag, 32'(rspAllow), 32'(expAllow));
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdChk(16, 32'h0000_0200, "R1 cfg reset");
    rdChk(0, 32'h0, "R1 win reset");
    chk(violFlag == 0, "R1 flag reset", 32'(violFlag), 0);
    // R7 bypass from reset
    accChk(32'h0030_0000, 1, 1, "R7 bypass open");
    // R3 window registers
    wr(0, 32'hFFFF_F002);
    rdChk(0, 32'h0000_0002, "R3 top nibble dropped");
    wr(8, 32'hFFFF_0005);
    rdChk(8, 32'h0000_0005, "R3 end readback");
    // R2 masked write keeps bypass
    wr(16, 32'h0001_0001);
    rdChk(16, 32'h0000_0201, "R2 masked set");
    wr(16, 32'h0200_0000);
    rdChk(16, 32'h0000_0001, "R2 masked clear");
    // R4/R5 window 0 = MB 2..5
    accChk(32'h0020_0000, 1, 0, "R4 start edge deny");
    chk(violAddr == 32'h0020_0000, "R10 addr captured", violAddr, 32'h0020_0000);
    accChk(32'h005F_FFFF, 1, 0, "R4 end edge deny");
    chk(violAddr == 32'h0020_0000, "R10 addr held", violAddr, 32'h0020_0000);
    accChk(32'h0060_0000, 1, 1, "R4 past end allow");
    accChk(32'h001F_FFFF, 1, 1, "R4 before start allow");
    accChk(32'h0030_0000, 0, 1, "R8 secure in window");
    // R11 clear
    rdChk(17, 32'h1, "R11 status set");
    wr(17, 32'h0000_0001);
    rdChk(17, 32'h0, "R11 status cleared");
    // R4 empty window 1: start 10 end 4
    wr(1, 32'hFFFF_000A);
    wr(9, 32'hFFFF_0004);
    wr(16, 32'h0002_0002);
    accChk(32'h0070_0000, 1, 1, "R4 empty window");
    // R6 outside secure
    wr(16, 32'h0100_0100);
    rdChk(16, 32'h0000_0103, "R2 outside bit");
    accChk(32'h0640_0000, 1, 0, "R6 outside deny");
    chk(violAddr == 32'h0640_0000, "R10 new capture", violAddr, 32'h0640_0000);
    accChk(32'h0640_0000, 0, 1, "R8 secure outside");
    // R11 clear and deny in the same cycle
    @(negedge clk);
    regWe = 1; regAddr = 17; regWdata = 32'h1;
    reqValid = 1; reqAddr = 32'h0700_0000; reqNs = 1;
    @(negedge clk);
    regWe = 0; reqValid = 0;
    chk(violFlag == 1, "R11 deny beats clear", 32'(violFlag), 1);
    chk(violAddr == 32'h0640_0000, "R10 addr kept", violAddr, 32'h0640_0000);
    wr(17, 32'h1);
    chk(violFlag == 0, "R11 clear", 32'(violFlag), 0);
    // R7 bypass overrides all
    wr(16, 32'h0200_0200);
    accChk(32'h0640_0000, 1, 1, "R7 bypass outside");
    accChk(32'h0020_0000, 1, 1, "R7 bypass window");
    // random phase, compared every cycle
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        int a;
        a = $urandom_range(0, 17);
        if (a < 16) wr(a, {16'hFFFF, 12'd0, 4'($urandom_range(0, 15))});
        else if (a == 16) wr(16, {16'($urandom), 6'd0, 1'b0, 9'($urandom)});
        else wr(17, 32'h1);
      end else if (r == 1) begin
        wr(16, {$urandom_range(0, 1) ? 16'h0200 : 16'h0000, 16'h0000});
      end else begin
        acc({4'd0, 8'($urandom_range(0, 15)), 20'($urandom)}, 1'($urandom));
      end
      if (n % 50 == 0) begin
        for (int a = 0; a < 18; a++) rdChk(a, modelRead(a), "R3 readback");
      end
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule